// File: doc/BRIEF.md
# Burst Waveform Sample Generator

This block produces a stream of 8-bit samples for a digital-to-analogue converter. A start request latches one of four shapes and a target channel. A sample-rate tick enable then steps a sample index through a fixed number of positions per period. Each tick yields one registered sample with a one-cycle valid pulse. After a set number of whole periods the block stops by itself. It pulses a done flag and parks the output at midscale. The defaults are 250 samples per period and 1000 periods per burst. With a 100 us tick this gives a 25 ms period and a 25 s burst.

A separate link block serialises the samples toward the converter, so that transfer is not part of this block. The sine shape is built from a quarter-wave magnitude table that is computed at elaboration and mirrored across the four quadrants. The other three shapes come from simple arithmetic on the same phase value.

Top module: `wg_burst_gen`

## Requirements
- R1: While reset is asserted and afterwards until a start is taken, sample_o is 0x80, and valid_o, busy_o and done_o are 0.
- R2: A start_i pulse while busy_o is 0 latches shape_i and chan_i, and busy_o is 1 from the next cycle. chan_o carries the latched code, where code 0 to 3 selects converter output 1 to 4.
- R3: While busy, every cycle with tick_i high produces exactly one sample: valid_o is high for one cycle, in the cycle after the tick. Ticks while idle produce no valid_o.
- R4: The phase of sample index k (0 to SPP-1) is p = floor(k*256/SPP). Shape code 0 (square) outputs 0xFF when p < 128 and 0x00 otherwise.
- R5: Shape code 2 (sawtooth) outputs p.
- R6: Shape code 3 (triangle) outputs 2*p for p < 128, and 255 - 2*(p-128) otherwise.
- R7: Shape code 1 (sine) splits p into a quadrant q = p/64 and an index i = p mod 64. It uses m = round(127*sin((j+0.5)*pi/128)), with j = i for even q and j = 63-i for odd q. The output is 128+m for q < 2 and 127-m otherwise.
- R8: A burst delivers exactly SPP*PERIODS samples, with the sample index wrapping each period. In the cycle after the last valid_o, done_o is high for one cycle and busy_o is 0. Later ticks produce nothing.
- R9: When the burst ends, sample_o returns to 0x80 and holds it while idle.
- R10: A start_i pulse during a burst is ignored, and so are changes of shape_i or chan_i. The running shape, channel and sample count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a burst (taken only when idle) |
| shape_i | input | 2 | Shape code: 0 square, 1 sine, 2 sawtooth, 3 triangle |
| chan_i | input | 2 | Target converter output code (0..3 = output 1..4) |
| tick_i | input | 1 | Sample-rate enable |
| sample_o | output | 8 | Current sample value |
| valid_o | output | 1 | One-cycle pulse per new sample |
| chan_o | output | 2 | Channel code latched at start |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at burst end |

## Verification
The properties assume that start_i and tick_i are synchronous to clk and settle well before the sampling edge. They also assume that one tick stands for one sample, so a tick held high for several cycles counts as several samples. The bench drives every input on the falling edge and raises tick_i for exactly one cycle at a time. Between ticks it sometimes leaves idle cycles. It fires start_i and alters shape_i and chan_i in the middle of a burst, so that the ignore rules are exercised inside the assumed input behaviour.

// File: rtl/wg_pkg.sv
// Shared types and elaboration-time helpers for the burst waveform generator.
// Assumes: sample width of at least 4 bits, so a quarter-wave table has >= 4 entries.
package wg_pkg;

    typedef enum logic [1:0] {
        SHP_SQUARE = 2'd0,
        SHP_SINE   = 2'd1,
        SHP_SAW    = 2'd2,
        SHP_TRI    = 2'd3
    } wg_shape_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } wg_state_e;

    // Magnitude of entry idx in an n-entry quarter-wave table, peak amp, sampled at bin centres.
    function automatic int qtr_mag(input int idx, input int n, input int amp);
        real ang;
        ang = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(n));
        return $rtoi(real'(amp) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/wg_sine_quarter.sv
// Quarter-wave sine source with mirroring.
// Maps a phase word to an offset sine sample: upper half-wave above midscale, lower below.
// Assumes: the phase word spans one full period over 2**DATA_W codes.
module wg_sine_quarter #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] phase_i,
    output logic [DATA_W-1:0] sine_o
);
    localparam int IDX_W = DATA_W - 2;
    localparam int QN    = 1 << IDX_W;
    localparam int AMP   = (1 << (DATA_W - 1)) - 1;

    logic [DATA_W-2:0] tbl [QN];
    logic [IDX_W-1:0]  ix;
    logic [DATA_W-2:0] mag;

    // Table entries are constants computed at elaboration.
    for (genvar g = 0; g < QN; g++) begin : g_tbl
        localparam int VI = wg_pkg::qtr_mag(g, QN, AMP);
        assign tbl[g] = VI[DATA_W-2:0];
    end

    // Mirror the index in odd quadrants, flip the sign in the lower half-wave.
    always_comb begin
        ix  = phase_i[DATA_W-2] ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];
        mag = tbl[ix];
        sine_o = phase_i[DATA_W-1] ? {1'b0, ~mag} : {1'b1, mag};
    end
endmodule

// File: rtl/wg_shaper.sv
// Converts a sample index into a shaped sample value.
// Assumes: index_i < SPP; the phase is floor(index*2**DATA_W/SPP).
module wg_shaper #(
    parameter int DATA_W = 8,
    parameter int SPP    = 250
) (
    input  logic [$clog2(SPP)-1:0] index_i,
    input  wg_pkg::wg_shape_e      shape_i,
    output logic [DATA_W-1:0]      sample_o
);
    localparam int KW = $clog2(SPP);
    localparam int NW = KW + DATA_W;

    logic [NW-1:0]     num;
    logic [NW-1:0]     quo;
    logic [DATA_W-1:0] phase;
    logic [DATA_W-1:0] ramp2;
    logic [DATA_W-1:0] sine;

    // Scale the index onto a full-range phase word.
    always_comb begin
        num   = {index_i, {DATA_W{1'b0}}};
        quo   = num / NW'(SPP);
        phase = quo[DATA_W-1:0];
        ramp2 = {phase[DATA_W-2:0], 1'b0};
    end

    wg_sine_quarter #(.DATA_W(DATA_W)) u_sine (
        .phase_i(phase),
        .sine_o (sine)
    );

    // Pick the shape.
    always_comb begin
        unique case (shape_i)
            wg_pkg::SHP_SQUARE: sample_o = phase[DATA_W-1] ? '0 : '1;
            wg_pkg::SHP_SINE:   sample_o = sine;
            wg_pkg::SHP_SAW:    sample_o = phase;
            default:            sample_o = phase[DATA_W-1] ? ~ramp2 : ramp2;
        endcase
    end
endmodule

// File: rtl/wg_sequencer.sv
// Burst control: latches shape and channel on start, steps the sample index on ticks,
// counts periods and drains for one cycle after the final sample.
// Assumes: SPP >= 2 and PERIODS >= 2.
module wg_sequencer #(
    parameter int SPP     = 250,
    parameter int PERIODS = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [1:0]             shape_i,
    input  logic [1:0]             chan_i,
    input  logic                   tick_i,
    output logic [$clog2(SPP)-1:0] index_o,
    output wg_pkg::wg_shape_e      shape_o,
    output logic [1:0]             chan_o,
    output logic                   emit_o,
    output logic                   fin_o,
    output logic                   busy_o
);
    localparam int KW = $clog2(SPP);
    localparam int PW = $clog2(PERIODS);
    localparam logic [KW-1:0] K_LAST = KW'(SPP - 1);
    localparam logic [PW-1:0] P_LAST = PW'(PERIODS - 1);

    wg_pkg::wg_state_e state_q;
    logic [KW-1:0]     k_q;
    logic [PW-1:0]     per_q;

    // Burst state machine with sample and period counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= wg_pkg::ST_IDLE;
            k_q     <= '0;
            per_q   <= '0;
            shape_o <= wg_pkg::SHP_SQUARE;
            chan_o  <= '0;
        end else begin
            unique case (state_q)
                wg_pkg::ST_IDLE: if (start_i) begin
                    state_q <= wg_pkg::ST_RUN;
                    k_q     <= '0;
                    per_q   <= '0;
                    shape_o <= wg_pkg::wg_shape_e'(shape_i);
                    chan_o  <= chan_i;
                end
                wg_pkg::ST_RUN: if (tick_i) begin
                    if (k_q == K_LAST) begin
                        k_q <= '0;
                        if (per_q == P_LAST) state_q <= wg_pkg::ST_DRAIN;
                        else                 per_q   <= per_q + 1'b1;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                default: state_q <= wg_pkg::ST_IDLE;
            endcase
        end
    end

    // Decoded controls for the output stage.
    always_comb begin
        index_o = k_q;
        emit_o  = (state_q == wg_pkg::ST_RUN) && tick_i;
        fin_o   = (state_q == wg_pkg::ST_DRAIN);
        busy_o  = (state_q != wg_pkg::ST_IDLE);
    end
endmodule

// File: rtl/wg_burst_gen.sv
// Top of the burst waveform generator: sequencer, shaper and registered output stage.
// Assumes: tick_i is a one-cycle-per-sample enable synchronous to clk.
module wg_burst_gen #(
    parameter int DATA_W  = 8,
    parameter int SPP     = 250,
    parameter int PERIODS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        shape_i,
    input  logic [1:0]        chan_i,
    input  logic              tick_i,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic [1:0]        chan_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int KW = $clog2(SPP);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

    logic [KW-1:0]      index;
    wg_pkg::wg_shape_e  shape;
    logic               emit;
    logic               fin;
    logic [DATA_W-1:0]  shaped;

    wg_sequencer #(.SPP(SPP), .PERIODS(PERIODS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .shape_i(shape_i),
        .chan_i (chan_i),
        .tick_i (tick_i),
        .index_o(index),
        .shape_o(shape),
        .chan_o (chan_o),
        .emit_o (emit),
        .fin_o  (fin),
        .busy_o (busy_o)
    );

    wg_shaper #(.DATA_W(DATA_W), .SPP(SPP)) u_shp (
        .index_i (index),
        .shape_i (shape),
        .sample_o(shaped)
    );

    // Register the sample, its strobe and the end-of-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= MID;
            valid_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            valid_o <= emit;
            done_o  <= fin;
            if (emit)     sample_o <= shaped;
            else if (fin) sample_o <= MID;
        end
    end
endmodule

// File: rtl/wg_burst_gen_chk.sv
// Protocol checker for wg_burst_gen, attached by bind.
// Assumes: inputs are synchronous to clk.
module wg_burst_gen_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              tick_i,
    input logic [DATA_W-1:0] sample_o,
    input logic              valid_o,
    input logic [1:0]        chan_o,
    input logic              busy_o,
    input logic              done_o
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

    a_r1_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !valid_o);
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    a_r3_valid_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(tick_i) && $past(busy_o));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !valid_o);
    a_r9_idle_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sample_o == MID);
    a_r10_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(chan_o));
endmodule

bind wg_burst_gen wg_burst_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick_i),
    .sample_o(sample_o),
    .valid_o (valid_o),
    .chan_o  (chan_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/sim_wg_burst_gen.sv
// Directed bench for wg_burst_gen with a short period and burst.
module sim_wg_burst_gen;
    localparam int SPP = 12;
    localparam int PER = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] shape_i = 2'd0;
    logic [1:0] chan_i = 2'd0;
    logic       tick_i = 1'b0;
    logic [7:0] sample_o;
    logic       valid_o;
    logic [1:0] chan_o;
    logic       busy_o;
    logic       done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wg_burst_gen #(.DATA_W(8), .SPP(SPP), .PERIODS(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shape_i(shape_i),
        .chan_i(chan_i), .tick_i(tick_i), .sample_o(sample_o), .valid_o(valid_o),
        .chan_o(chan_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expect_sample(input int shape, input int k);
        int p, q, i, j, m;
        p = (k * 256) / SPP;
        case (shape)
            0: return (p < 128) ? 255 : 0;
            2: return p;
            3: return (p < 128) ? 2 * p : 255 - 2 * (p - 128);
            default: begin
                q = p / 64;
                i = p % 64;
                j = (q % 2 == 1) ? 63 - i : i;
                m = $rtoi(127.0 * $sin((real'(j) + 0.5) * 3.14159265358979 / 128.0) + 0.5);
                return (q < 2) ? 128 + m : 127 - m;
            end
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check(sample_o == 8'h80, "R1 sample", sample_o, 128);
        check(!valid_o && !busy_o && !done_o, "R1 flags", {valid_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        step();
        check(sample_o == 8'h80 && !busy_o, "R1 after release", sample_o, 128);
    endtask

    task automatic t_idle_tick();
        for (int i = 0; i < 4; i++) begin
            tick_i = 1'b1;
            step();
            tick_i = 1'b0;
            check(!valid_o, "R3 idle tick no valid", valid_o, 0);
            check(sample_o == 8'h80, "R9 idle midscale", sample_o, 128);
        end
    endtask

    task automatic t_burst(input int shape, input int chan, input bit gaps, input bit intrude);
        int k;
        shape_i = 2'(shape);
        chan_i  = 2'(chan);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        check(busy_o, "R2 busy after start", busy_o, 1);
        check(chan_o == 2'(chan), "R2 channel latched", chan_o, chan);
        for (int n = 0; n < SPP * PER; n++) begin
            k = n % SPP;
            if (gaps) begin
                step();
                check(!valid_o, "R3 no valid without tick", valid_o, 0);
            end
            if (intrude && n == 5) begin
                start_i = 1'b1;
                shape_i = 2'(shape + 1);
                chan_i  = 2'(chan + 1);
                step();
                start_i = 1'b0;
                check(busy_o && chan_o == 2'(chan), "R10 start ignored", chan_o, chan);
            end
            check(busy_o, "R8 busy before last sample", busy_o, 1);
            tick_i = 1'b1;
            step();
            tick_i = 1'b0;
            check(valid_o, "R3 valid after tick", valid_o, 1);
            case (shape)
                0: check(sample_o == 8'(expect_sample(0, k)), "R4 square", sample_o, expect_sample(0, k));
                1: check(sample_o == 8'(expect_sample(1, k)), "R7 sine", sample_o, expect_sample(1, k));
                2: check(sample_o == 8'(expect_sample(2, k)), "R5 sawtooth", sample_o, expect_sample(2, k));
                default: check(sample_o == 8'(expect_sample(3, k)), "R6 triangle", sample_o, expect_sample(3, k));
            endcase
        end
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
        check(done_o && !busy_o, "R8 done pulse, busy low", {done_o, busy_o}, 2);
        check(!valid_o, "R8 no sample past burst", valid_o, 0);
        check(sample_o == 8'h80, "R9 midscale at end", sample_o, 128);
        step();
        check(!done_o, "R8 done one cycle", done_o, 0);
        check(sample_o == 8'h80, "R9 midscale held", sample_o, 128);
        step();
    endtask

    initial begin
        t_reset();
        t_idle_tick();
        t_burst(0, 0, 1'b0, 1'b0);
        t_burst(2, 1, 1'b1, 1'b0);
        t_burst(3, 2, 1'b0, 1'b1);
        t_burst(1, 3, 1'b1, 1'b0);
        t_burst(1, 0, 1'b0, 1'b1);
        t_idle_tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule